// File: doc/BRIEF.md
# Winding Step Sequencer

This block runs a coil-winding machine through a list of preset steps kept in an external byte memory. When `start` is pulsed while motor power is present (`enable` high), it clears its address pointer and its encoder count. For each step it then fetches two bytes over a simple request/acknowledge port. Together the two bytes form a four-digit BCD target. The block runs the motor in the reverse direction and counts debounced falling edges from the motor encoder in decimal.

When the count reaches the target, the motor stops, the count is cleared and both relay outputs close. The sequencer then holds until the drum sensor gives its once-per-revolution falling edge. After that edge it fetches the next step, or returns to idle once the programmed number of steps is done. Dropping `enable` stops everything at once. Each sensor input is synchronised, edge-detected and followed by a lockout window that suppresses contact bounce.

Top module: `winding_sequencer`

## Requirements
- R1: After reset, motor_run, motor_dir, relay_a, relay_b and mem_req are 0 and count_bcd is 0000.
- R2: A run starts on start=1 while enable=1 and the step total (total_bytes divided by two, rounded down) is non-zero. The address pointer is cleared and then pre-incremented before every fetch, so step i reads addresses 2i-1 and then 2i. mem_req stays high with a stable mem_addr until mem_ack, and mem_data is taken in the ack cycle.
- R3: The first byte of a step gives target bits 7:0 (the two low BCD digits). The second byte gives bits 15:8 (the two high digits).
- R4: While a step is counting toward its target, motor_run=1 and motor_dir=1. In every other state both are 0, and no fetch overlaps a running motor.
- R5: count_bcd holds four BCD digits, each at most 9. Every accepted encoder edge adds one in decimal, and a low byte going past 99 becomes 00 and carries into the high byte.
- R6: Encoder edges are counted only while the motor runs. While the sequencer waits for the drum, count_bcd does not change.
- R7: When count_bcd equals the target, the count is cleared, the motor stops and relay_a and relay_b both go to 1. The relays stay at 1 until the sequencer returns to idle.
- R8: After a step completes, the next fetch waits for an accepted drum falling edge. Drum edges that arrive while the motor is running have no effect.
- R9: The drum edge that follows the last step returns the block to idle: motor off, relays 0, no request. A start with a step total of zero (total_bytes of 0 or 1) fetches nothing.
- R10: A falling edge on encoder_n or drum_n is accepted only if at least LOCK_CYC cycles have passed since the last accepted edge on that same input. A bounce inside that window counts once.
- R11: enable=0 forces idle at the next clock edge from any state: motor off, relays 0, no request. A start pulse while enable=0 is ignored.
- R12: Every accepted start clears count_bcd to 0000 before the first step runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Motor power present; low forces idle |
| start | input | 1 | Begin a run from idle |
| total_bytes | input | ADDR_W | Programmed byte count; steps = total_bytes/2 |
| mem_req | output | 1 | Byte fetch request |
| mem_addr | output | ADDR_W | Address of the requested byte |
| mem_ack | input | 1 | Fetch completed this cycle |
| mem_data | input | DATA_W | Fetched byte, valid with mem_ack |
| encoder_n | input | 1 | Raw motor encoder, falling edge counts |
| drum_n | input | 1 | Raw drum revolution sensor, falling edge |
| motor_run | output | 1 | Motor drive enable |
| motor_dir | output | 1 | Motor direction, 1 = reverse |
| relay_a | output | 1 | First relay drive |
| relay_b | output | 1 | Second relay drive |
| count_bcd | output | 2*DATA_W | Current BCD encoder count |

## Verification
The bench aims at the hundreds carry, using a target of 0101. A design that forgets the carry, or compares the wrong byte order, never matches, so the motor never stops and the watchdog expires. It sends drum pulses while the motor is running and encoder pulses while the sequencer waits for the drum. A design that ignored the state here would advance a step early or leave a non-zero count. It also sends a bounce inside the lockout window, drops enable halfway through a step, and uses step totals of zero and of an odd byte count. Broken gating in any of these shows up as an extra count, a motor that keeps running, or a fetch from a wrong address.

// File: rtl/wseq_pkg.sv
package wseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_FETCH_LO  = 3'd1,
        ST_FETCH_HI  = 3'd2,
        ST_RUN       = 3'd3,
        ST_WAIT_DRUM = 3'd4
    } seq_state_e;

    localparam logic [3:0] BCD_MAX = 4'd9;

    // One decimal digit step: returns the incremented digit, wrapping 9 to 0.
    function automatic logic [3:0] bcd_digit_step(input logic [3:0] dig);
        return (dig == BCD_MAX) ? 4'd0 : dig + 4'd1;
    endfunction

endpackage

// File: rtl/wseq_edge_lock.sv
module wseq_edge_lock #(
    parameter int LOCK_CYC = 200000,
    localparam int LOCK_W = $clog2(LOCK_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic evt
);

    typedef struct packed {
        logic [1:0]        sync;
        logic              prev;
        logic [LOCK_W-1:0] hold;
    } lock_t;

    lock_t r_d, r_q;
    logic  fall;

    always_comb begin
        r_d      = r_q;
        r_d.sync = {r_q.sync[0], pin_n};
        r_d.prev = r_q.sync[1];
        fall     = r_q.prev & ~r_q.sync[1];
        evt      = fall & (r_q.hold == '0);
        if (evt) begin
            r_d.hold = LOCK_W'(LOCK_CYC);
        end else if (r_q.hold != '0) begin
            r_d.hold = r_q.hold - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.sync <= 2'b11;
            r_q.prev <= 1'b1;
            r_q.hold <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/wseq_bcd_count.sv
module wseq_bcd_count
    import wseq_pkg::*;
#(
    parameter int DIGITS = 4,
    localparam int CW = 4 * DIGITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] count
);

    logic [3:0]        dig_d [DIGITS];
    logic [3:0]        dig_q [DIGITS];
    logic [DIGITS-1:0] carry;

    assign carry[0] = inc;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        if (g < DIGITS - 1) begin : g_chain
            assign carry[g+1] = carry[g] & (dig_q[g] == BCD_MAX);
        end

        always_comb begin
            if (clr) begin
                dig_d[g] = 4'd0;
            end else if (carry[g]) begin
                dig_d[g] = bcd_digit_step(dig_q[g]);
            end else begin
                dig_d[g] = dig_q[g];
            end
        end

        assign count[4*g +: 4] = dig_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DIGITS; i++) dig_q[i] <= 4'd0;
        end else begin
            for (int i = 0; i < DIGITS; i++) dig_q[i] <= dig_d[i];
        end
    end

endmodule

// File: rtl/wseq_step_fsm.sv
module wseq_step_fsm
    import wseq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              start,
    input  logic [ADDR_W-1:0] total_bytes,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_data,
    input  logic              enc_evt,
    input  logic              drum_evt,
    input  logic [CNT_W-1:0]  count,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              motor_run,
    output logic              motor_dir,
    output logic              relay_on,
    output logic              cnt_clr,
    output logic              cnt_inc
);

    typedef struct packed {
        seq_state_e        state;
        logic [ADDR_W-1:0] ptr;
        logic [CNT_W-1:0]  target;
        logic [ADDR_W-1:0] steps_done;
        logic              relay;
    } fsm_t;

    fsm_t              s_d, s_q;
    logic [ADDR_W-1:0] total_steps;
    logic              hit;

    assign total_steps = total_bytes >> 1;
    assign hit         = (count == s_q.target);

    always_comb begin
        s_d     = s_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        if (!enable) begin
            s_d.state = ST_IDLE;
            s_d.relay = 1'b0;
        end else begin
            unique case (s_q.state)
                ST_IDLE: begin
                    if (start) begin
                        s_d.ptr        = ADDR_W'(1);
                        s_d.steps_done = '0;
                        s_d.relay      = 1'b0;
                        cnt_clr        = 1'b1;
                        if (total_steps != '0) s_d.state = ST_FETCH_LO;
                    end
                end
                ST_FETCH_LO: begin
                    if (mem_ack) begin
                        s_d.target[DATA_W-1:0] = mem_data;
                        s_d.ptr                = s_q.ptr + 1'b1;
                        s_d.state              = ST_FETCH_HI;
                    end
                end
                ST_FETCH_HI: begin
                    if (mem_ack) begin
                        s_d.target[CNT_W-1:DATA_W] = mem_data;
                        s_d.state                  = ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (hit) begin
                        cnt_clr        = 1'b1;
                        s_d.relay      = 1'b1;
                        s_d.steps_done = s_q.steps_done + 1'b1;
                        s_d.state      = ST_WAIT_DRUM;
                    end else if (enc_evt) begin
                        cnt_inc = 1'b1;
                    end
                end
                ST_WAIT_DRUM: begin
                    if (drum_evt) begin
                        if (s_q.steps_done == total_steps) begin
                            s_d.state = ST_IDLE;
                            s_d.relay = 1'b0;
                        end else begin
                            s_d.ptr   = s_q.ptr + 1'b1;
                            s_d.state = ST_FETCH_LO;
                        end
                    end
                end
                default: s_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state      <= ST_IDLE;
            s_q.ptr        <= '0;
            s_q.target     <= '0;
            s_q.steps_done <= '0;
            s_q.relay      <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_req   = (s_q.state == ST_FETCH_LO) || (s_q.state == ST_FETCH_HI);
    assign mem_addr  = s_q.ptr;
    assign motor_run = (s_q.state == ST_RUN);
    assign motor_dir = (s_q.state == ST_RUN);
    assign relay_on  = s_q.relay;

endmodule

// File: rtl/winding_sequencer.sv
module winding_sequencer #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int LOCK_CYC = 200000,
    localparam int CNT_W   = 2 * DATA_W,
    localparam int DIGITS  = CNT_W / 4,
    localparam int N_SENSE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              start,
    input  logic [ADDR_W-1:0] total_bytes,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_data,
    input  logic              encoder_n,
    input  logic              drum_n,
    output logic              motor_run,
    output logic              motor_dir,
    output logic              relay_a,
    output logic              relay_b,
    output logic [CNT_W-1:0]  count_bcd
);

    logic [N_SENSE-1:0] raw_n;
    logic [N_SENSE-1:0] evt;
    logic               cnt_clr;
    logic               cnt_inc;
    logic               relay_on;

    assign raw_n = {drum_n, encoder_n};

    for (genvar k = 0; k < N_SENSE; k++) begin : g_sense
        wseq_edge_lock #(.LOCK_CYC(LOCK_CYC)) u_lock (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_n (raw_n[k]),
            .evt   (evt[k])
        );
    end

    wseq_bcd_count #(.DIGITS(DIGITS)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .count (count_bcd)
    );

    wseq_step_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .start       (start),
        .total_bytes (total_bytes),
        .mem_ack     (mem_ack),
        .mem_data    (mem_data),
        .enc_evt     (evt[0]),
        .drum_evt    (evt[1]),
        .count       (count_bcd),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .motor_run   (motor_run),
        .motor_dir   (motor_dir),
        .relay_on    (relay_on),
        .cnt_clr     (cnt_clr),
        .cnt_inc     (cnt_inc)
    );

    assign relay_a = relay_on;
    assign relay_b = relay_on;

endmodule

// File: rtl/wseq_checker.sv
module wseq_checker #(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              motor_run,
    input logic              motor_dir,
    input logic              relay_a,
    input logic              relay_b,
    input logic [CNT_W-1:0]  count_bcd
);

    logic [ADDR_W-1:0] addr_plus;
    logic              bcd_ok;

    assign addr_plus = mem_addr + 1'b1;

    always_comb begin
        bcd_ok = 1'b1;
        for (int i = 0; i < CNT_W / 4; i++) begin
            if (count_bcd[4*i +: 4] > 4'd9) bcd_ok = 1'b0;
        end
    end

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && enable) |=> (mem_req && $stable(mem_addr)));

    assert_addr_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && enable) |=> (!mem_req || mem_addr == $past(addr_plus)));

    assert_no_fetch_while_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !motor_run);

    assert_reverse_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
        motor_run |-> motor_dir);

    assert_bcd_digits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bcd_ok);

    assert_relay_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        relay_a == relay_b);

    assert_enable_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!motor_run && !mem_req && !relay_a));

endmodule

bind winding_sequencer wseq_checker #(.ADDR_W(ADDR_W), .CNT_W(2 * DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .motor_run (motor_run),
    .motor_dir (motor_dir),
    .relay_a   (relay_a),
    .relay_b   (relay_b),
    .count_bcd (count_bcd)
);

// File: tb/tb_winding_sequencer.sv
`timescale 1ns/1ps
module tb_winding_sequencer;

    localparam int AW   = 8;
    localparam int DW   = 8;
    localparam int LOCK = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] total_bytes = '0;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_ack = 1'b0;
    logic [DW-1:0] mem_data = '0;
    logic          encoder_n = 1'b1;
    logic          drum_n = 1'b1;
    logic          motor_run, motor_dir, relay_a, relay_b;
    logic [15:0]   count_bcd;

    int vectors = 0;
    int fails   = 0;
    int exp_addr = 1;
    bit finished = 0;
    logic [7:0] mem [0:255];

    always #5 clk = ~clk;

    winding_sequencer #(.ADDR_W(AW), .DATA_W(DW), .LOCK_CYC(LOCK)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
        .total_bytes(total_bytes), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_data(mem_data), .encoder_n(encoder_n),
        .drum_n(drum_n), .motor_run(motor_run), .motor_dir(motor_dir),
        .relay_a(relay_a), .relay_b(relay_b), .count_bcd(count_bcd)
    );

    function automatic logic [15:0] to_bcd(input int v);
        return {4'(v / 1000 % 10), 4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Memory responder: acks after a random delay, checks the requested address (R2).
    initial begin
        int delay = 0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (delay == 0) begin
                    check(mem_addr == AW'(exp_addr), "R2", mem_addr, exp_addr);
                    mem_data = mem[mem_addr];
                    mem_ack  = 1'b1;
                    exp_addr++;
                    delay = int'($urandom % 3);
                end else begin
                    delay--;
                end
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic enc_pulse();
        @(negedge clk) encoder_n = 1'b0;
        repeat (3) @(negedge clk);
        encoder_n = 1'b1;
        repeat (14) @(negedge clk);
    endtask

    task automatic drum_pulse();
        @(negedge clk) drum_n = 1'b0;
        repeat (3) @(negedge clk);
        drum_n = 1'b1;
        repeat (14) @(negedge clk);
    endtask

    task automatic wait_run();
        for (int t = 0; t < 300 && !motor_run; t++) @(negedge clk);
    endtask

    task automatic load_step(input int idx, input int n);
        logic [15:0] b;
        b = to_bcd(n);
        mem[2*idx-1] = b[7:0];
        mem[2*idx]   = b[15:8];
    endtask

    task automatic run_step(input int n, input bit drum_mid, input bit last);
        wait_run();
        check(motor_run && motor_dir, "R4", {motor_run, motor_dir}, 2'b11);
        for (int k = 0; k < n - 1; k++) enc_pulse();
        if (drum_mid) begin
            drum_pulse();
            check(motor_run == 1'b1, "R8", motor_run, 1);
        end
        check(count_bcd == to_bcd(n - 1), "R5", count_bcd, to_bcd(n - 1));
        enc_pulse();
        check(!motor_run && !motor_dir, "R4", {motor_run, motor_dir}, 0);
        check(relay_a && relay_b && count_bcd == 0, "R7", {relay_a, relay_b, count_bcd}, 18'h30000);
        enc_pulse();
        check(count_bcd == 0 && !motor_run, "R6", count_bcd, 0);
        check(!mem_req, "R8", mem_req, 0);
        drum_pulse();
        if (last) begin
            repeat (5) @(negedge clk);
            check(!motor_run && !relay_a && !mem_req, "R9",
                  {motor_run, relay_a, mem_req}, 0);
        end else begin
            check(relay_a == 1'b1, "R7", relay_a, 1);
        end
    endtask

    task automatic do_run(input int steps[], input int tb_bytes, input int mid_idx);
        for (int i = 0; i < steps.size(); i++) load_step(i + 1, steps[i]);
        total_bytes = AW'(tb_bytes);
        exp_addr = 1;
        pulse_start();
        for (int i = 0; i < steps.size(); i++)
            run_step(steps[i], i == mid_idx, i == steps.size() - 1);
    endtask

    initial begin
        int rs[];
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!motor_run && !motor_dir && !relay_a && !relay_b && !mem_req && count_bcd == 0,
              "R1", {motor_run, motor_dir, relay_a, relay_b, mem_req}, 0);

        // R11: start ignored while enable is low
        total_bytes = 8'd2;
        load_step(1, 3);
        pulse_start();
        repeat (6) @(negedge clk);
        check(!mem_req && !motor_run, "R11", {mem_req, motor_run}, 0);
        enable = 1'b1;

        // Directed: three steps, odd byte total 7, hundreds carry at 0101 (R3, R5)
        do_run('{5, 101, 7}, 7, 0);

        // R10: bounce inside lockout counts once
        load_step(1, 9);
        total_bytes = 8'd2;
        exp_addr = 1;
        pulse_start();
        wait_run();
        @(negedge clk) encoder_n = 1'b0;
        repeat (2) @(negedge clk);
        encoder_n = 1'b1;
        repeat (2) @(negedge clk);
        encoder_n = 1'b0;
        repeat (2) @(negedge clk);
        encoder_n = 1'b1;
        repeat (16) @(negedge clk);
        check(count_bcd == 16'h0001, "R10", count_bcd, 16'h0001);

        // R11: enable drop mid-step forces idle
        enc_pulse();
        @(negedge clk) enable = 1'b0;
        @(negedge clk);
        check(!motor_run && !relay_a && !mem_req, "R11", {motor_run, relay_a, mem_req}, 0);
        check(count_bcd == 16'h0002, "R11", count_bcd, 16'h0002);
        enable = 1'b1;

        // R12: restart clears the count, fetch restarts at address 1
        load_step(1, 4);
        exp_addr = 1;
        pulse_start();
        wait_run();
        check(count_bcd == 0, "R12", count_bcd, 0);
        run_step(4, 1'b0, 1'b1);

        // R9: zero step total
        total_bytes = 8'd1;
        pulse_start();
        repeat (8) @(negedge clk);
        check(!mem_req && !motor_run, "R9", {mem_req, motor_run}, 0);

        // Random runs
        for (int r = 0; r < 3; r++) begin
            int ns;
            ns = 2 + int'($urandom % 3);
            rs = new[ns];
            for (int i = 0; i < ns; i++) rs[i] = 1 + int'($urandom % 15);
            do_run(rs, 2 * ns, int'($urandom % ns));
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            vectors++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule